// File: doc/BRIEF.md
# I2C Own-Address Matcher

This unit decides, for an I2C target, whether the address phase that follows a start condition names this device. Software loads the device address through two byte-wide configuration writes: a low byte and a high byte that holds the width select and the two top address bits. The unit then watches the address bytes that the bit-level receiver hands over after each start. It issues an acknowledge decision at each address byte's acknowledge slot and raises a held matched flag, together with the transfer direction, once the whole address has been recognised.

Both 7-bit and 10-bit addressing are handled. Only one width is live at a time, and addresses of the other width are always refused. In 10-bit mode a write header is followed by the low address byte. After a complete 10-bit match, a repeated start followed by a read header completes the match on its own, with no further low byte.

Top module: `i2c_own_addr_match`

## Requirements
- R1: After reset the outputs ack_strobe, ack_value, addr_matched and dir_read are 0. The stored address is 0 and the unit is in 7-bit mode.
- R2: A pulse on wr_lo stores all 8 bits of wdata as the low address byte. A pulse on wr_hi stores wdata bit 7 as the width select (0 = 7-bit, 1 = 10-bit) and wdata bits 2:1 as address bits 9:8. All other wdata bits on a wr_hi write have no effect.
- R3: In 7-bit mode, the first byte after a start matches when its bits 7:1 equal low-byte bits 7:1. Low-byte bit 0 takes no part in this compare. On a match dir_read takes the byte's bit 0 (1 = read).
- R4: One cycle after each byte_valid that carries an address byte, ack_strobe is high for one cycle. In that cycle ack_value is 1 for ACK and 0 for NACK, and addr_matched/dir_read show the new result.
- R5: With ack_en at 0, every address byte gets NACK and addr_matched stays 0.
- R6: In 10-bit mode, the first byte must be {11110, addr[9:8], 0}. It is ACKed without setting addr_matched. The next byte must equal the low address byte, and on that match it gets ACK, addr_matched goes to 1 and dir_read goes to 0. A mismatch in either byte gives NACK.
- R7: In 7-bit mode, any first byte whose bits 7:3 are 11110 is refused. In 10-bit mode, any first byte whose bits 7:3 are not 11110 is refused.
- R8: After a complete 10-bit match, a repeated start followed by {11110, addr[9:8], 1} gets ACK and sets addr_matched with dir_read = 1 at once. Without such a preceding match, that read header gets NACK.
- R9: A stop clears addr_matched and dir_read one cycle later. It also cancels any pending read restart.
- R10: A start clears addr_matched one cycle later. After a NACK, and after a completed match, further bytes produce no strobe until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_lo | input | 1 | Write strobe for the low address byte |
| wr_hi | input | 1 | Write strobe for the high configuration byte |
| wdata | input | 8 | Configuration write data |
| ack_en | input | 1 | Acknowledge enable |
| bus_start | input | 1 | Start or repeated start detected (one-cycle pulse) |
| bus_stop | input | 1 | Stop detected (one-cycle pulse) |
| byte_valid | input | 1 | A received byte is ready at its acknowledge slot |
| byte_data | input | 8 | The received byte |
| ack_strobe | output | 1 | One-cycle acknowledge decision strobe |
| ack_value | output | 1 | Decision during ack_strobe: 1 = ACK, 0 = NACK |
| addr_matched | output | 1 | Address phase matched, held until start or stop |
| dir_read | output | 1 | Direction of the matched transfer, 1 = read |

## Verification
A wrong phase state shows up on the strobe of the very next address byte. If the unit is stuck in the wrong phase, a second byte is refused, or a byte after a NACK still gets a strobe. A lost or stale restart permission shows up as a wrong decision on the read header directly after the repeated start. A bad width select or compare shows up as a wrong ack_value one cycle after the byte. Every such fault is visible within one byte of the transaction in which it arises.

// File: rtl/oam_pkg.sv
package oam_pkg;

    localparam int BYTE_W = 8;
    localparam int HI_W   = 2;
    localparam int HDR_W  = BYTE_W - HI_W - 1;
    localparam logic [HDR_W-1:0] HDR_TAG = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_MATCH,
        ST_SKIP
    } phase_e;

    typedef struct packed {
        phase_e st;
        logic   armed;
        logic   strobe;
        logic   ackv;
        logic   matched;
        logic   rd;
    } fsm_t;

endpackage

// File: rtl/oam_addr_regs.sv
module oam_addr_regs
    import oam_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo_addr,
    output logic [HI_W-1:0]   hi_addr,
    output logic              ten_bit
);

    logic [BYTE_W-1:0] lo_d, lo_q;
    logic [HI_W-1:0]   hi_d, hi_q;
    logic              mode_d, mode_q;

    always_comb begin
        lo_d   = lo_q;
        hi_d   = hi_q;
        mode_d = mode_q;
        if (wr_lo) lo_d = wdata;
        if (wr_hi) begin
            mode_d = wdata[BYTE_W-1];
            hi_d   = wdata[HI_W:1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            mode_q <= 1'b0;
        end else begin
            lo_q   <= lo_d;
            hi_q   <= hi_d;
            mode_q <= mode_d;
        end
    end

    assign lo_addr = lo_q;
    assign hi_addr = hi_q;
    assign ten_bit = mode_q;

endmodule

// File: rtl/oam_compare.sv
module oam_compare
    import oam_pkg::*;
(
    input  logic [BYTE_W-1:0] rx,
    input  logic [BYTE_W-1:0] lo_addr,
    input  logic [HI_W-1:0]   hi_addr,
    output logic              hit7,
    output logic              hdr_wr,
    output logic              hdr_rd,
    output logic              low_hit
);

    logic is_hdr;
    logic hdr_hi;

    always_comb begin
        is_hdr  = (rx[BYTE_W-1 -: HDR_W] == HDR_TAG);
        hdr_hi  = is_hdr && (rx[HI_W:1] == hi_addr);
        hit7    = !is_hdr && (rx[BYTE_W-1:1] == lo_addr[BYTE_W-1:1]);
        hdr_wr  = hdr_hi && !rx[0];
        hdr_rd  = hdr_hi &&  rx[0];
        low_hit = (rx == lo_addr);
    end

endmodule

// File: rtl/i2c_own_addr_match.sv
module i2c_own_addr_match
    import oam_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_lo,
    input  logic       wr_hi,
    input  logic [7:0] wdata,
    input  logic       ack_en,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    output logic       ack_strobe,
    output logic       ack_value,
    output logic       addr_matched,
    output logic       dir_read
);

    logic [BYTE_W-1:0] lo_addr;
    logic [HI_W-1:0]   hi_addr;
    logic              ten_bit;
    logic              hit7, hdr_wr, hdr_rd, low_hit;

    oam_addr_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wdata   (wdata),
        .lo_addr (lo_addr),
        .hi_addr (hi_addr),
        .ten_bit (ten_bit)
    );

    oam_compare u_cmp (
        .rx      (byte_data),
        .lo_addr (lo_addr),
        .hi_addr (hi_addr),
        .hit7    (hit7),
        .hdr_wr  (hdr_wr),
        .hdr_rd  (hdr_rd),
        .low_hit (low_hit)
    );

    fsm_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.strobe = 1'b0;
        s_d.ackv   = 1'b0;
        if (bus_stop) begin
            s_d.st      = ST_IDLE;
            s_d.armed   = 1'b0;
            s_d.matched = 1'b0;
            s_d.rd      = 1'b0;
        end else if (bus_start) begin
            s_d.st      = ST_FIRST;
            s_d.armed   = s_q.armed && (s_q.st == ST_MATCH);
            s_d.matched = 1'b0;
            s_d.rd      = 1'b0;
        end else if (byte_valid) begin
            case (s_q.st)
                ST_FIRST: begin
                    s_d.strobe = 1'b1;
                    s_d.st     = ST_SKIP;
                    s_d.armed  = 1'b0;
                    if (!ten_bit) begin
                        if (hit7 && ack_en) begin
                            s_d.ackv    = 1'b1;
                            s_d.matched = 1'b1;
                            s_d.rd      = byte_data[0];
                            s_d.st      = ST_MATCH;
                        end
                    end else if (hdr_rd) begin
                        if (s_q.armed && ack_en) begin
                            s_d.ackv    = 1'b1;
                            s_d.matched = 1'b1;
                            s_d.rd      = 1'b1;
                            s_d.armed   = 1'b1;
                            s_d.st      = ST_MATCH;
                        end
                    end else if (hdr_wr && ack_en) begin
                        s_d.ackv = 1'b1;
                        s_d.st   = ST_SECOND;
                    end
                end
                ST_SECOND: begin
                    s_d.strobe = 1'b1;
                    s_d.st     = ST_SKIP;
                    if (low_hit && ack_en) begin
                        s_d.ackv    = 1'b1;
                        s_d.matched = 1'b1;
                        s_d.rd      = 1'b0;
                        s_d.armed   = 1'b1;
                        s_d.st      = ST_MATCH;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, armed: 1'b0, strobe: 1'b0, ackv: 1'b0,
                     matched: 1'b0, rd: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ack_strobe   = s_q.strobe;
    assign ack_value    = s_q.ackv;
    assign addr_matched = s_q.matched;
    assign dir_read     = s_q.rd;

    // R5: an ACK only follows a cycle with ack_en high
    p_ack_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_strobe && ack_value) |-> $past(ack_en));

    // R4: the matched flag only rises together with an ACK strobe
    p_match_with_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_matched) |-> (ack_strobe && ack_value));

    // R9: a stop leaves the flag clear on the next cycle
    p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (!addr_matched && !dir_read));

    // R10: a start leaves the flag clear on the next cycle
    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !addr_matched);

    // R10: no strobe once a match is already held
    p_quiet_after_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_matched && $past(addr_matched)) |-> !ack_strobe);

    // R3: a read direction can only be reported with a match
    p_dir_with_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dir_read |-> addr_matched);

endmodule

// File: tb/tb_i2c_own_addr_match.sv
`timescale 1ns/1ps
module tb_i2c_own_addr_match;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_lo = 1'b0, wr_hi = 1'b0;
    logic [7:0] wdata = '0;
    logic       ack_en = 1'b1;
    logic       bus_start = 1'b0, bus_stop = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       ack_strobe, ack_value, addr_matched, dir_read;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    i2c_own_addr_match dut (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wdata),
        .ack_en(ack_en), .bus_start(bus_start), .bus_stop(bus_stop),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .ack_strobe(ack_strobe), .ack_value(ack_value),
        .addr_matched(addr_matched), .dir_read(dir_read)
    );

    logic [7:0] m_lo;
    logic [1:0] m_hi;
    logic       m_ten;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [7:0] lo, input logic [7:0] hi);
        @(negedge clk); wr_lo = 1'b1; wdata = lo;
        @(negedge clk); wr_lo = 1'b0; wr_hi = 1'b1; wdata = hi;
        @(negedge clk); wr_hi = 1'b0;
        m_lo = lo; m_hi = hi[2:1]; m_ten = hi[7];
    endtask

    task automatic do_start();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); byte_valid = 1'b1; byte_data = b;
        @(negedge clk); byte_valid = 1'b0;
    endtask

    function automatic logic exp7(input logic [7:0] b, input logic en);
        return en && (b[7:3] != 5'b11110) && (b[7:1] == m_lo[7:1]);
    endfunction

    function automatic logic [7:0] hdr(input logic rd);
        return {5'b11110, m_hi, rd};
    endfunction

    // strobe, value, matched, dir after a byte
    task automatic expect_byte(input string tag, input logic v, input logic m, input logic d);
        chk({tag, " strobe"}, ack_strobe, 1'b1);
        chk({tag, " value"}, ack_value, v);
        chk({tag, " matched"}, addr_matched, m);
        chk({tag, " dir"}, dir_read, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] b, b2, b3;
        logic e1, e2, e3;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 strobe", ack_strobe, 0);
        chk("R1 value", ack_value, 0);
        chk("R1 matched", addr_matched, 0);
        chk("R1 dir", dir_read, 0);
        rst_n = 1'b1;
        m_lo = 8'h00; m_hi = 2'b00; m_ten = 1'b0;
        // R1: reset address 0 in 7-bit mode, so 0x01 is a read match
        do_start(); send(8'h01); expect_byte("R1 default addr", 1, 1, 1);
        do_stop();
        chk("R9 stop clears matched", addr_matched, 0);
        chk("R9 stop clears dir", dir_read, 0);

        // R3: low bit 0 ignored in 7-bit mode
        cfg(8'hA5, 8'h40);
        do_start(); send(8'hA4); expect_byte("R3 bit0 ignored", 1, 1, 0);
        send(8'hA4);
        chk("R10 no strobe after match", ack_strobe, 0);
        do_start();
        chk("R10 start clears matched", addr_matched, 0);
        send(8'h12); expect_byte("R3 mismatch", 0, 0, 0);
        send(8'hA4);
        chk("R10 no strobe after nack", ack_strobe, 0);
        do_stop();

        // R5: ack disabled
        ack_en = 1'b0;
        do_start(); send(8'hA5); expect_byte("R5 ack off", 0, 0, 0);
        do_stop(); ack_en = 1'b1;

        // R7: 7-bit mode with own address in the header range is refused
        cfg(8'hF2, 8'h40);
        do_start(); send(8'hF2); expect_byte("R7 header in 7-bit", 0, 0, 0);
        do_stop();

        // R2: stray bits in the high byte ignored; 0xFF gives 10-bit, bits 9:8 = 11
        cfg(8'h3C, 8'hFF);
        do_start(); send(8'h1E); expect_byte("R7 7-bit in 10-bit", 0, 0, 0);
        do_start(); send(8'hF6); expect_byte("R2 R6 header", 1, 0, 0);
        send(8'h3C); expect_byte("R6 low byte", 1, 1, 0);
        do_start(); send(8'hF7); expect_byte("R8 read restart", 1, 1, 1);
        do_stop();
        do_start(); send(8'hF7); expect_byte("R9 R8 read after stop", 0, 0, 0);
        do_start(); send(8'hF6); expect_byte("R6 header again", 1, 0, 0);
        send(8'h3D); expect_byte("R6 low mismatch", 0, 0, 0);
        do_start(); send(8'hF7); expect_byte("R8 read without match", 0, 0, 0);
        do_stop();

        // random transactions
        for (int i = 0; i < 300; i++) begin
            logic [7:0] lo, hi;
            lo = 8'($urandom);
            hi = 8'($urandom) | 8'h40;
            ack_en = (($urandom % 8) != 0);
            cfg(lo, hi);
            do_start();
            chk("R10 start", addr_matched, 0);
            if (!m_ten) begin
                b = ($urandom % 2) ? {m_lo[7:1], 1'($urandom)} : 8'($urandom);
                e1 = exp7(b, ack_en);
                send(b); expect_byte("R3 R4 random 7-bit", e1, e1, e1 & b[0]);
            end else begin
                case ($urandom % 3)
                    0: b = hdr(1'b0);
                    1: b = {5'b11110, 2'($urandom), 1'($urandom)};
                    default: b = 8'($urandom);
                endcase
                e1 = ack_en && (b == hdr(1'b0));
                send(b); expect_byte("R6 R7 random header", e1, 0, 0);
                if (e1) begin
                    b2 = ($urandom % 2) ? m_lo : 8'($urandom);
                    e2 = ack_en && (b2 == m_lo);
                    send(b2); expect_byte("R6 random low", e2, e2, 0);
                    if (e2) begin
                        do_start();
                        b3 = ($urandom % 2) ? hdr(1'b1) : {5'b11110, 2'($urandom), 1'b1};
                        e3 = ack_en && (b3 == hdr(1'b1));
                        send(b3); expect_byte("R8 random restart", e3, e3, e3);
                    end
                end
            end
            send(8'($urandom));
            chk("R10 random extra byte", ack_strobe, 0);
            do_stop();
            chk("R9 random stop", addr_matched, 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule